// File: doc/BRIEF.md
# Manchester Data Recovery Unit

This block turns a sliced, oversampled Manchester-coded bit stream into regenerated NRZ data and a recovered bit clock. A 1.2 MHz tick enable paces all internal state. A phase counter acts as a digital phase-locked loop: it spans one bit period, and every data transition pulls it toward lock. The pull is proportional and coarse in wide mode, for acquisition on an alternating preamble. In narrow mode it is a single tick, which gives low jitter while tracking random data.

The decoded stream is the incoming data XORed with the recovered clock. An up/down counter integrates it over the whole bit period. At the end of the period the sum is compared with a signed threshold. The bit is then emitted with a one-cycle strobe, and the counter is cleared. The threshold normally sits at zero (majority) and is driven from a configuration register outside the block.

Top module: `mdr_top`

## Requirements
- R1: After reset, `bit_stb_o`, `nrz_o` and `rec_clk_o` are all 0.
- R2: A bit period is 150 ticks when `rate_fast_i`=0 (8 kHz) and 120 ticks when `rate_fast_i`=1 (10 kHz). Once per period, the cycle after the period's last tick, `bit_stb_o` is high for exactly one clock.
- R3: `rec_clk_o` is 0 for the first half of the period's ticks and 1 for the second half. A 1 bit is therefore sent high-then-low and a 0 bit low-then-high.
- R4: Each tick adds +1 to the bit sum when `data_i` XOR `rec_clk_o` is 1, and adds -1 otherwise.
- R5: At the period end, `nrz_o` becomes 1 only if the sum strictly exceeds `thresh_i`, which is 10-bit two's complement. The sum then restarts from zero.
- R6: With `narrow_i`=0, each data transition measures the phase error e = phase - period/2. The phase moves against e by ceil(|e|/2) ticks.
- R7: With `narrow_i`=1, a transition with 0 < |e| < period/4 moves the phase by one tick against e. All other transitions are ignored.
- R8: While `tick_i` is low, the phase, the bit sum and the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 1.2 MHz sample enable |
| data_i | input | 1 | Sliced Manchester data sample |
| rate_fast_i | input | 1 | 0: 8 kHz bit rate, 1: 10 kHz |
| narrow_i | input | 1 | 0: wide loop gain, 1: narrow loop gain |
| thresh_i | input | 10 | Signed decision threshold |
| rec_clk_o | output | 1 | Recovered bit clock |
| bit_stb_o | output | 1 | One-cycle pulse per decided bit |
| nrz_o | output | 1 | Regenerated NRZ bit |

## Verification
Clean aligned streams with runs of equal bits, at both rates, show that the strobe falls on the last tick and the decided value is correct. A bit with its mid transition moved by 40 ticks is decided against thresholds of 69, 70 and -151. That brackets the exact integrated count and the strict signed comparison. Alternating preambles that start 40 or 3 ticks late separate the loop modes. Wide gain halves the offset on each bit, which can be seen in the strobe positions 129, 139 and then lock. Narrow gain ignores the 40-tick edges, keeping the strobe at tick 109, and walks the 3-tick offset in one tick per bit. A 30-cycle tick gap in mid-bit checks that every output holds.

// File: rtl/mdr_pkg.sv
package mdr_pkg;
  localparam int DEF_TICK_HZ = 1_200_000;
  localparam int DEF_SLOW_HZ = 8_000;
  localparam int DEF_FAST_HZ = 10_000;

  function automatic int ticks_per_bit(int tick_hz, int bit_hz);
    return tick_hz / bit_hz;
  endfunction
endpackage

// File: rtl/mdr_edge_det.sv
module mdr_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic data_i,
  output logic edge_o
);
  logic prev_q, seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (tick_i) begin
      prev_q <= data_i;
      seen_q <= 1'b1;
    end
  end

  // first sample after reset has no predecessor
  assign edge_o = tick_i && seen_q && (data_i != prev_q);
endmodule

// File: rtl/mdr_dpll.sv
module mdr_dpll #(
  parameter int P_SLOW     = 150,
  parameter int P_FAST     = 120,
  parameter int WIDE_SHIFT = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rate_fast_i,
  input  logic narrow_i,
  input  logic edge_i,
  output logic rec_clk_o,
  output logic end_o
);
  localparam int P_MAX = (P_SLOW > P_FAST) ? P_SLOW : P_FAST;
  localparam int PH_W  = $clog2(P_MAX);
  localparam int SW    = PH_W + 2;
  localparam logic signed [SW-1:0] S_ONE = SW'(1);
  localparam logic signed [SW-1:0] S_RND = SW'((1 << WIDE_SHIFT) - 1);

  logic [PH_W-1:0] ph_q, ph_d, period, half, quarter;
  logic signed [SW-1:0] err, mag, step_mag, step, raw, per_s;

  assign period  = rate_fast_i ? PH_W'(P_FAST) : PH_W'(P_SLOW);
  assign half    = period >> 1;
  assign quarter = period >> 2;
  assign per_s   = $signed({2'b00, period});

  always_comb begin
    err = $signed({2'b00, ph_q}) - $signed({2'b00, half});
    mag = err[SW-1] ? -err : err;
    if (narrow_i)
      step_mag = (mag != '0 && mag < $signed({2'b00, quarter})) ? S_ONE : '0;
    else
      step_mag = (mag + S_RND) >>> WIDE_SHIFT;
    step = edge_i ? (err[SW-1] ? -step_mag : step_mag) : '0;
    raw  = $signed({2'b00, ph_q}) + S_ONE - step;
    if (raw >= per_s)     raw = raw - per_s;
    else if (raw < 0)     raw = raw + per_s;
    ph_d = raw[PH_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ph_q <= '0;
    else if (tick_i)  ph_q <= ph_d;
  end

  assign rec_clk_o = (ph_q >= half);
  assign end_o     = tick_i && (ph_q >= period - PH_W'(1));

  AST_PHASE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q < PH_W'(P_MAX)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(ph_q)); // R8
endmodule

// File: rtl/mdr_integrator.sv
module mdr_integrator #(
  parameter int ACC_W = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic                    end_i,
  input  logic                    dec_i,
  input  logic signed [ACC_W-1:0] thresh_i,
  output logic                    bit_stb_o,
  output logic                    nrz_o
);
  localparam logic signed [ACC_W-1:0] S_UP = ACC_W'(1);
  localparam logic signed [ACC_W-1:0] S_DN = -S_UP;

  logic signed [ACC_W-1:0] acc_q, total;

  assign total = acc_q + (dec_i ? S_UP : S_DN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      nrz_o     <= 1'b0;
      bit_stb_o <= 1'b0;
    end else begin
      bit_stb_o <= tick_i && end_i;
      if (tick_i) begin
        if (end_i) begin
          nrz_o <= (total > thresh_i);
          acc_q <= '0;
        end else begin
          acc_q <= total;
        end
      end
    end
  end

  AST_STB_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb_o |=> !bit_stb_o); // R2
  AST_STB_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb_o |-> $past(tick_i)); // R2
  AST_ACC_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb_o |-> (acc_q == '0)); // R5
  AST_IDLE_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(acc_q) && $stable(nrz_o))); // R8
endmodule

// File: rtl/mdr_top.sv
module mdr_top
  import mdr_pkg::*;
#(
  parameter int TICK_HZ    = DEF_TICK_HZ,
  parameter int SLOW_HZ    = DEF_SLOW_HZ,
  parameter int FAST_HZ    = DEF_FAST_HZ,
  parameter int WIDE_SHIFT = 1,
  localparam int P_SLOW    = ticks_per_bit(TICK_HZ, SLOW_HZ),
  localparam int P_FAST    = ticks_per_bit(TICK_HZ, FAST_HZ),
  localparam int P_MAX     = (P_SLOW > P_FAST) ? P_SLOW : P_FAST,
  localparam int THR_W     = $clog2(P_MAX) + 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic                    data_i,
  input  logic                    rate_fast_i,
  input  logic                    narrow_i,
  input  logic signed [THR_W-1:0] thresh_i,
  output logic                    rec_clk_o,
  output logic                    bit_stb_o,
  output logic                    nrz_o
);
  logic edge_w, end_w, rclk_w, dec_w;

  mdr_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .data_i (data_i),
    .edge_o (edge_w)
  );

  mdr_dpll #(
    .P_SLOW     (P_SLOW),
    .P_FAST     (P_FAST),
    .WIDE_SHIFT (WIDE_SHIFT)
  ) u_dpll (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .rate_fast_i (rate_fast_i),
    .narrow_i    (narrow_i),
    .edge_i      (edge_w),
    .rec_clk_o   (rclk_w),
    .end_o       (end_w)
  );

  assign dec_w = data_i ^ rclk_w;

  mdr_integrator #(.ACC_W(THR_W)) u_integ (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .end_i     (end_w),
    .dec_i     (dec_w),
    .thresh_i  (thresh_i),
    .bit_stb_o (bit_stb_o),
    .nrz_o     (nrz_o)
  );

  assign rec_clk_o = rclk_w;
endmodule

// File: tb/tb_mdr_top.sv
module tb_mdr_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, data = 1'b0;
  logic rate_fast = 1'b0, narrow = 1'b1;
  logic signed [9:0] thresh = '0;
  logic rec_clk, bit_stb, nrz;

  int total = 0, bad = 0, cur_p = 150;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdr_top dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .data_i(data),
    .rate_fast_i(rate_fast), .narrow_i(narrow), .thresh_i(thresh),
    .rec_clk_o(rec_clk), .bit_stb_o(bit_stb), .nrz_o(nrz)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic fast, input logic nar);
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; data = 1'b0;
    rate_fast = fast; narrow = nar; thresh = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_p = fast ? 120 : 150;
    @(negedge clk);
  endtask

  task automatic one_tick(input logic d, output logic stb, output logic n, output logic rc);
    rc = rec_clk;
    data = d; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    stb = bit_stb; n = nrz;
    @(negedge clk);
  endtask

  task automatic send_raw(input logic d, input int n);
    logic s, v, r;
    for (int i = 0; i < n; i++) one_tick(d, s, v, r);
  endtask

  task automatic send_bit(input logic b, input int corrupt, input int idle_at,
                          output int stb_pos, output int stb_cnt, output logic nrz_v,
                          output int clk_err, output int idle_bad);
    int h;
    logic d, s, v, rc, r0;
    h = cur_p / 2;
    stb_pos = -1; stb_cnt = 0; nrz_v = 1'b0; clk_err = 0; idle_bad = 0;
    for (int i = 0; i < cur_p; i++) begin
      d = (i < h) ? b : ~b;
      if (i >= h && i < h + corrupt) d = b;
      if (i == idle_at) begin
        r0 = rec_clk;
        for (int k = 0; k < 30; k++) begin
          @(negedge clk);
          if (rec_clk !== r0 || bit_stb !== 1'b0) idle_bad++;
        end
      end
      one_tick(d, s, v, rc);
      if (rc !== (i >= h)) clk_err++;
      if (s) begin stb_cnt++; stb_pos = i; nrz_v = v; end
    end
  endtask

  task automatic check_bit(input logic b, input string req);
    int pos, cnt, ce, ib;
    logic v;
    send_bit(b, 0, -1, pos, cnt, v, ce, ib);
    chk(cnt == 1 && pos == cur_p - 1, {req, " R2 strobe pos"}, pos, cur_p - 1);
    chk(v === b, {req, " R4 R5 nrz"}, int'(v), int'(b));
    chk(ce == 0, {req, " R3 rec_clk halves"}, ce, 0);
  endtask

  task automatic t_reset();
    do_reset(1'b0, 1'b1);
    chk(bit_stb === 1'b0 && nrz === 1'b0 && rec_clk === 1'b0, "R1 reset outputs",
        int'({bit_stb, nrz, rec_clk}), 0);
  endtask

  task automatic t_slow_data();
    logic [7:0] pat = 8'b1000_1011;
    do_reset(1'b0, 1'b1);
    for (int i = 0; i < 8; i++) check_bit(pat[i], "slow data");
  endtask

  task automatic t_idle();
    int pos, cnt, ce, ib;
    logic v;
    do_reset(1'b0, 1'b1);
    send_bit(1'b1, 0, 40, pos, cnt, v, ce, ib);
    chk(ib == 0, "R8 idle hold mid-bit", ib, 0);
    chk(cnt == 1 && pos == 149 && v === 1'b1, "R8 bit after idle gap", pos, 149);
    send_bit(1'b0, 0, 100, pos, cnt, v, ce, ib);
    chk(ib == 0 && cnt == 1 && pos == 149 && v === 1'b0, "R8 idle second half", ib, 0);
  endtask

  task automatic t_fast_data();
    logic [4:0] pat = 5'b10110;
    do_reset(1'b1, 1'b1);
    for (int i = 0; i < 5; i++) check_bit(pat[i], "fast R2 120 ticks");
  endtask

  task automatic t_threshold();
    int pos, cnt, ce, ib;
    logic v;
    do_reset(1'b0, 1'b1);
    thresh = 10'sd69;
    send_bit(1'b0, 0, -1, pos, cnt, v, ce, ib);
    chk(v === 1'b0, "R5 clean zero thr 69", int'(v), 0);
    send_bit(1'b1, 40, -1, pos, cnt, v, ce, ib);
    chk(cnt == 1 && v === 1'b1, "R4 sum 70 > thr 69", int'(v), 1);
    send_bit(1'b0, 0, -1, pos, cnt, v, ce, ib);
    thresh = 10'sd70;
    send_bit(1'b1, 40, -1, pos, cnt, v, ce, ib);
    chk(cnt == 1 && pos == 149 && v === 1'b0, "R5 sum 70 not > thr 70", int'(v), 0);
    send_bit(1'b0, 0, -1, pos, cnt, v, ce, ib);
    thresh = -10'sd151;
    send_bit(1'b0, 0, -1, pos, cnt, v, ce, ib);
    chk(v === 1'b1, "R5 signed thr -151", int'(v), 1);
  endtask

  task automatic t_wide_acq();
    int pos, cnt, ce, ib;
    logic v;
    do_reset(1'b0, 1'b0);
    send_raw(1'b1, 40);
    send_bit(1'b1, 0, -1, pos, cnt, v, ce, ib);
    chk(cnt == 1 && pos == 129, "R6 wide first step 20", pos, 129);
    send_bit(1'b0, 0, -1, pos, cnt, v, ce, ib);
    chk(cnt == 1 && pos == 139, "R6 wide second step 10", pos, 139);
    for (int i = 0; i < 10; i++) send_bit(i[0] ? 1'b0 : 1'b1, 0, -1, pos, cnt, v, ce, ib);
    for (int i = 0; i < 6; i++) check_bit(i[0] ? 1'b0 : 1'b1, "R6 wide locked");
  endtask

  task automatic t_narrow_ignore();
    int pos, cnt, ce, ib;
    logic v;
    do_reset(1'b0, 1'b1);
    send_raw(1'b1, 40);
    for (int i = 0; i < 6; i++) begin
      send_bit(i[0] ? 1'b0 : 1'b1, 0, -1, pos, cnt, v, ce, ib);
      chk(cnt == 1 && pos == 109, "R7 narrow ignores far edge", pos, 109);
    end
  endtask

  task automatic t_narrow_track();
    int pos, cnt, ce, ib;
    logic v;
    do_reset(1'b0, 1'b1);
    send_raw(1'b1, 3);
    send_bit(1'b1, 0, -1, pos, cnt, v, ce, ib);
    chk(cnt == 1 && pos == 147, "R7 narrow one-tick step", pos, 147);
    for (int i = 0; i < 3; i++) send_bit(i[0] ? 1'b1 : 1'b0, 0, -1, pos, cnt, v, ce, ib);
    for (int i = 0; i < 4; i++) check_bit(i[0] ? 1'b0 : 1'b1, "R7 narrow locked");
  endtask

  initial begin
    t_reset();
    t_slow_data();
    t_idle();
    t_fast_data();
    t_threshold();
    t_wide_acq();
    t_narrow_ignore();
    t_narrow_track();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule